// File: doc/BRIEF.md
# LCD Pixel Tile-Row Ring Buffer

This block takes a 160x144 handheld-style LCD pixel stream and rebuilds it as planar two-bit-per-pixel tile rows. The stream carries a 2-bit value per pixel and has horizontal and vertical sync pulses. Each tile row is eight scanlines tall. While a row is being captured, it is written into one slot of a four-slot ring. The other three slots hold finished rows, and a host can copy them out at any time.

The host uses a small byte-wide register window with three registers:
- A status byte reports the tile row being drawn and the slot being filled.
- A select register picks the slot to copy out.
- A data port at one fixed address returns successive bytes of the selected slot on every read. When the slot runs out, the port returns a fixed filler pattern, and after that the same slot repeats.

Top module: `lcd_tilerow_ring`

## Requirements
- R1: While reset is asserted and after it is released, host_rdata is 0x00. A status read made right after reset returns 0x00 (tile row 0, write slot 0). The select register starts at 0 and the readout counter starts at 0.
- R2: A pixel is accepted on a cycle with pix_valid high and hsync and vsync low, only while fewer than 160 pixels have been taken on the current line. Pixels of line L (0..7) of tile column T (0..19) are stored in the current slot as follows:
  - Bit 0 of the eight pixels goes to byte 16T+2L.
  - Bit 1 of the eight pixels goes to byte 16T+2L+1.
  - The leftmost pixel goes to bit 7.
- R3: The hsync pulse that ends the eighth line of a tile row advances the write slot by one, modulo 4.
- R4: A read at address 0 returns status. Bits 7..3 hold the current tile row, bit 2 is 0, and bits 1..0 hold the write slot. Any read result appears on host_rdata in the cycle after the read strobe and is held until the next read.
- R5: When the eighteenth tile row of a frame completes, status bits 7..3 read 0x11 until the next vsync.
- R6: A vsync pulse sets the tile row and the line-within-row back to 0 and leaves the write slot unchanged.
- R7: A write at address 1 takes bits 1..0 of host_wdata as the selected slot and sets the readout counter to 0.
- R8: A read at address 2 returns the byte of the selected slot indexed by the readout counter, then increments the counter. The counter does not change on any other cycle.
- R9: Readout counter values 320 to 511 return 0xFF. After 512 reads the counter wraps to 0, so the slot's bytes repeat.
- R10: Reads at address 1 or address 3 return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_data | input | 2 | Pixel shade value |
| hsync | input | 1 | Ends the current line |
| vsync | input | 1 | Starts a new frame |
| host_addr | input | 2 | Register address: 0 status, 1 select, 2 data |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid from the cycle after the strobe |

## Verification
On every cycle, the assertions check the following:
- the write slot steps by one when a row closes;
- vsync clears the reported tile row;
- a select write rewinds the readout counter;
- a read in the overrun window yields 0xFF;
- the counter stays put when no data read or select write is made.

The bench scenarios are needed for the byte content of each slot, which depends on the order of the plane bits. They also cover the 0x11 vertical-blank code, the repeat after 512 reads, a vsync arriving in the middle of a row, and the status encoding. A behavioural model checks all of these against host_rdata on every clock.

// File: rtl/lcdring_pkg.sv
package lcdring_pkg;

  // Host register addresses
  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_SELECT = 2'd1,
    REG_DATA   = 2'd2,
    REG_SPARE  = 2'd3
  } reg_sel_e;

  // Source of the held read result
  typedef enum logic [1:0] {
    RK_STATUS = 2'd0,
    RK_DATA   = 2'd1,
    RK_ONES   = 2'd2
  } rd_kind_e;

endpackage

// File: rtl/lcdring_packer.sv
module lcdring_packer #(
  parameter int WIDTH     = 160,
  parameter int ROW_LINES = 8,
  parameter int SLOTS     = 4
) (
  input  logic                                                   clk,
  input  logic                                                   rst_n,
  input  logic                                                   pix_valid,
  input  logic [1:0]                                             pix_data,
  input  logic                                                   hsync,
  input  logic                                                   vsync,
  input  logic [$clog2(SLOTS)-1:0]                               wr_slot,
  output logic                                                   mem_we,
  output logic [$clog2(SLOTS*(WIDTH/8)*ROW_LINES)-1:0]           mem_waddr,
  output logic [15:0]                                            mem_wdata,
  output logic                                                   row_done
);
  localparam int TILES  = WIDTH / 8;
  localparam int WPS    = TILES * ROW_LINES;
  localparam int MEM_AW = $clog2(SLOTS * WPS);
  localparam int COL_W  = $clog2(WIDTH + 1);
  localparam int LINE_W = $clog2(ROW_LINES);

  logic [COL_W-1:0]  col_q, col_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic [7:0]        lo_q, lo_d, hi_q, hi_d;
  logic              we_q, we_d;
  logic [MEM_AW-1:0] waddr_q, waddr_d;
  logic [15:0]       wdata_q, wdata_d;
  logic              take_pix;

  assign take_pix = pix_valid && !hsync && !vsync && (col_q < COL_W'(WIDTH));

  always_comb begin
    col_d    = col_q;
    line_d   = line_q;
    lo_d     = lo_q;
    hi_d     = hi_q;
    we_d     = 1'b0;
    waddr_d  = waddr_q;
    wdata_d  = wdata_q;
    row_done = 1'b0;
    if (vsync) begin
      col_d  = '0;
      line_d = '0;
    end else if (hsync) begin
      col_d = '0;
      if (line_q == LINE_W'(ROW_LINES - 1)) begin
        line_d   = '0;
        row_done = 1'b1;
      end else begin
        line_d = line_q + 1'b1;
      end
    end else if (take_pix) begin
      lo_d  = {lo_q[6:0], pix_data[0]};
      hi_d  = {hi_q[6:0], pix_data[1]};
      col_d = col_q + 1'b1;
      if (col_q[2:0] == 3'd7) begin
        we_d    = 1'b1;
        waddr_d = MEM_AW'(wr_slot) * MEM_AW'(WPS)
                + MEM_AW'(col_q >> 3) * MEM_AW'(ROW_LINES)
                + MEM_AW'(line_q);
        wdata_d = {hi_d, lo_d};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q   <= '0;
      line_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      col_q  <= col_d;
      line_q <= line_d;
      we_q   <= we_d;
      if (take_pix) begin
        lo_q <= lo_d;
        hi_q <= hi_d;
      end
      if (we_d) begin
        waddr_q <= waddr_d;
        wdata_q <= wdata_d;
      end
    end
  end

  assign mem_we    = we_q;
  assign mem_waddr = waddr_q;
  assign mem_wdata = wdata_q;

  // A store write always follows an accepted pixel
  assert_write_follows_pixel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(pix_valid));

endmodule

// File: rtl/lcdring_rowtrack.sv
module lcdring_rowtrack #(
  parameter int HEIGHT      = 144,
  parameter int ROW_LINES   = 8,
  parameter int SLOTS       = 4,
  parameter logic [4:0] VBLANK_CODE = 5'h11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     row_done,
  input  logic                     vsync,
  output logic [$clog2(SLOTS)-1:0] wr_slot,
  output logic [4:0]               status_row
);
  localparam int ROWS   = HEIGHT / ROW_LINES;
  localparam int SLOT_W = $clog2(SLOTS);

  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [4:0]        row_q, row_d;
  logic              vb_q, vb_d;

  always_comb begin
    slot_d = slot_q;
    row_d  = row_q;
    vb_d   = vb_q;
    if (vsync) begin
      row_d = '0;
      vb_d  = 1'b0;
    end else if (row_done) begin
      slot_d = slot_q + 1'b1;
      if (row_q == 5'(ROWS - 1)) vb_d  = 1'b1;
      else                       row_d = row_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      row_q  <= '0;
      vb_q   <= 1'b0;
    end else begin
      slot_q <= slot_d;
      row_q  <= row_d;
      vb_q   <= vb_d;
    end
  end

  assign wr_slot    = slot_q;
  assign status_row = vb_q ? VBLANK_CODE : row_q;

  assert_slot_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    row_done |=> (wr_slot == SLOT_W'($past(wr_slot) + 1'b1)));

  assert_vsync_row_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> (status_row == 5'd0));

endmodule

// File: rtl/lcdring_store.sv
module lcdring_store #(
  parameter int DEPTH = 640
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [15:0]              wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [15:0]              rdata
);
  logic [15:0] mem [DEPTH];
  logic [15:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/lcdring_reader.sv
module lcdring_reader
  import lcdring_pkg::*;
#(
  parameter int WIDTH     = 160,
  parameter int ROW_LINES = 8,
  parameter int SLOTS     = 4,
  parameter int OVERRUN   = 192
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic [1:0]                                    host_addr,
  input  logic                                          host_rd,
  input  logic                                          host_wr,
  input  logic [7:0]                                    host_wdata,
  input  logic [4:0]                                    status_row,
  input  logic [$clog2(SLOTS)-1:0]                      wr_slot,
  input  logic [15:0]                                   mem_rdata,
  output logic                                          mem_re,
  output logic [$clog2(SLOTS*(WIDTH/8)*ROW_LINES)-1:0]  mem_raddr,
  output logic [7:0]                                    host_rdata
);
  localparam int WPS    = (WIDTH / 8) * ROW_LINES;
  localparam int BYTES  = WPS * 2;
  localparam int PERIOD = BYTES + OVERRUN;
  localparam int CNT_W  = $clog2(PERIOD);
  localparam int MEM_AW = $clog2(SLOTS * WPS);
  localparam int SLOT_W = $clog2(SLOTS);

  logic [SLOT_W-1:0] sel_q, sel_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  rd_kind_e          kind_q, kind_d;
  logic [7:0]        stat_q, stat_d;
  logic              bsel_q, bsel_d;
  logic              data_rd, sel_wr, in_range;

  assign data_rd  = host_rd && (host_addr == REG_DATA);
  assign sel_wr   = host_wr && (host_addr == REG_SELECT);
  assign in_range = cnt_q < CNT_W'(BYTES);

  assign mem_re    = data_rd && in_range;
  assign mem_raddr = MEM_AW'(sel_q) * MEM_AW'(WPS) + MEM_AW'(cnt_q >> 1);

  always_comb begin
    sel_d  = sel_q;
    cnt_d  = cnt_q;
    kind_d = kind_q;
    stat_d = stat_q;
    bsel_d = bsel_q;
    if (host_rd) begin
      case (reg_sel_e'(host_addr))
        REG_STATUS: begin
          kind_d = RK_STATUS;
          stat_d = 8'({status_row, 1'b0, wr_slot});
        end
        REG_DATA: begin
          kind_d = in_range ? RK_DATA : RK_ONES;
          bsel_d = cnt_q[0];
          cnt_d  = (cnt_q == CNT_W'(PERIOD - 1)) ? '0 : cnt_q + 1'b1;
        end
        default: kind_d = RK_ONES;
      endcase
    end
    if (sel_wr) begin
      sel_d = host_wdata[SLOT_W-1:0];
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      cnt_q  <= '0;
      kind_q <= RK_STATUS;
      stat_q <= '0;
      bsel_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
      stat_q <= stat_d;
      bsel_q <= bsel_d;
    end
  end

  always_comb begin
    case (kind_q)
      RK_STATUS: host_rdata = stat_q;
      RK_DATA:   host_rdata = bsel_q ? mem_rdata[15:8] : mem_rdata[7:0];
      default:   host_rdata = 8'hFF;
    endcase
  end

  assert_select_rewind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> (cnt_q == '0));

  assert_overrun_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !in_range) |=> (host_rdata == 8'hFF));

  assert_counter_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_rd && !sel_wr) |=> $stable(cnt_q));

endmodule

// File: rtl/lcd_tilerow_ring.sv
module lcd_tilerow_ring #(
  parameter int WIDTH     = 160,
  parameter int HEIGHT    = 144,
  parameter int ROW_LINES = 8,
  parameter int SLOTS     = 4,
  parameter int OVERRUN   = 192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pix_valid,
  input  logic [1:0] pix_data,
  input  logic       hsync,
  input  logic       vsync,
  input  logic [1:0] host_addr,
  input  logic       host_rd,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata
);
  localparam int DEPTH  = SLOTS * (WIDTH / 8) * ROW_LINES;
  localparam int MEM_AW = $clog2(DEPTH);
  localparam int SLOT_W = $clog2(SLOTS);

  logic              rst_meta_q, rst_sync_q;
  logic [SLOT_W-1:0] wr_slot;
  logic [4:0]        status_row;
  logic              row_done;
  logic              mem_we, mem_re;
  logic [MEM_AW-1:0] mem_waddr, mem_raddr;
  logic [15:0]       mem_wdata, mem_rdata;

  // Reset asserts at once and is released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  lcdring_packer #(.WIDTH(WIDTH), .ROW_LINES(ROW_LINES), .SLOTS(SLOTS)) u_packer (
    .clk(clk), .rst_n(rst_sync_q), .pix_valid(pix_valid), .pix_data(pix_data),
    .hsync(hsync), .vsync(vsync), .wr_slot(wr_slot), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .row_done(row_done));

  lcdring_rowtrack #(.HEIGHT(HEIGHT), .ROW_LINES(ROW_LINES), .SLOTS(SLOTS)) u_rowtrack (
    .clk(clk), .rst_n(rst_sync_q), .row_done(row_done), .vsync(vsync),
    .wr_slot(wr_slot), .status_row(status_row));

  lcdring_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(mem_re), .raddr(mem_raddr), .rdata(mem_rdata));

  lcdring_reader #(.WIDTH(WIDTH), .ROW_LINES(ROW_LINES), .SLOTS(SLOTS),
                   .OVERRUN(OVERRUN)) u_reader (
    .clk(clk), .rst_n(rst_sync_q), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .status_row(status_row),
    .wr_slot(wr_slot), .mem_rdata(mem_rdata), .mem_re(mem_re),
    .mem_raddr(mem_raddr), .host_rdata(host_rdata));

endmodule

// File: tb/lcd_tilerow_ring_tb.sv
module lcd_tilerow_ring_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, pix_valid, hsync, vsync, host_rd, host_wr;
  logic [1:0] pix_data, host_addr;
  logic [7:0] host_wdata, host_rdata;

  lcd_tilerow_ring u_dut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .hsync(hsync), .vsync(vsync), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata));

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string req = "R1";
  logic [7:0] exp_rd = 8'h00;

  // Behavioural model state
  int ref_mem [4][320];
  int m_slot = 0, m_row = 0, m_vb = 0, m_line = 0, m_col = 0, m_sel = 0, m_cnt = 0;
  int gline = 0;

  function automatic void check(string r, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s host_rdata actual %02h expected %02h", r, act, exp);
    end
  endfunction

  function automatic logic [1:0] pixv(int gl, int c);
    return 2'((c + (c >> 3) * gl + gl * 3) & 3);
  endfunction

  // One clock: compare last result, drive new inputs, advance the model
  task automatic cyc(input logic pv, input logic [1:0] pd, input logic hs, input logic vs,
                     input logic [1:0] addr, input logic rd, input logic wr,
                     input logic [7:0] wd);
    @(negedge clk);
    check(req, host_rdata, exp_rd);
    pix_valid = pv; pix_data = pd; hsync = hs; vsync = vs;
    host_addr = addr; host_rd = rd; host_wr = wr; host_wdata = wd;
    if (rd) begin
      if (addr == 2'd0) exp_rd = 8'(((m_vb != 0 ? 17 : m_row) << 3) | m_slot);
      else if (addr == 2'd2) begin
        exp_rd = (m_cnt < 320) ? 8'(ref_mem[m_sel][m_cnt]) : 8'hFF;
        m_cnt = (m_cnt + 1) % 512;
      end else exp_rd = 8'hFF;
    end
    if (wr && addr == 2'd1) begin
      m_sel = wd & 3;
      m_cnt = 0;
    end
    if (vs) begin
      m_col = 0; m_line = 0; m_row = 0; m_vb = 0;
    end else if (hs) begin
      m_col = 0;
      if (m_line == 7) begin
        m_line = 0;
        m_slot = (m_slot + 1) % 4;
        if (m_row == 17) m_vb = 1;
        else m_row++;
      end else m_line++;
    end else if (pv && m_col < 160) begin
      int idx = (m_col / 8) * 16 + m_line * 2;
      int b = 7 - (m_col % 8);
      ref_mem[m_slot][idx]     = (ref_mem[m_slot][idx]     & ~(1 << b)) | (int'(pd[0]) << b);
      ref_mem[m_slot][idx + 1] = (ref_mem[m_slot][idx + 1] & ~(1 << b)) | (int'(pd[1]) << b);
      m_col++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 8'd0);
  endtask

  task automatic rd(input logic [1:0] a);
    cyc(1'b0, 2'd0, 1'b0, 1'b0, a, 1'b1, 1'b0, 8'd0);
  endtask

  task automatic sel(input int s);
    cyc(1'b0, 2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 8'(s));
  endtask

  task automatic vs_pulse();
    cyc(1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 8'd0);
  endtask

  // One line: 160 pixels with a few idle gaps, one stray pixel past the edge, then hsync
  task automatic feed_line();
    for (int c = 0; c < 160; c++) begin
      if (c % 37 == 5) idle(1);
      cyc(1'b1, pixv(gline, c), 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 8'd0);
    end
    cyc(1'b1, 2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 8'd0);
    cyc(1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 8'd0);
    gline++;
  endtask

  task automatic feed_row();
    for (int l = 0; l < 8; l++) feed_line();
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog %s actual timeout expected completion", req);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pix_valid = 1'b0; pix_data = 2'd0; hsync = 1'b0; vsync = 1'b0;
    host_addr = 2'd0; host_rd = 1'b0; host_wr = 1'b0; host_wdata = 8'd0;
    for (int s = 0; s < 4; s++) for (int i = 0; i < 320; i++) ref_mem[s][i] = 0;
    // R1: reset value of the read port and of the status register
    repeat (3) @(negedge clk);
    check("R1", host_rdata, 8'h00);
    rst_n = 1'b1;
    req = "R1";
    idle(4);
    rd(2'd0);
    idle(1);

    // R3/R4: three rows, status after each (expected row n, slot n)
    req = "R6"; vs_pulse();
    req = "R3";
    for (int r = 0; r < 3; r++) begin
      feed_row();
      req = "R4"; rd(2'd0); idle(1); req = "R3";
    end

    // R10: spare and select addresses read as ones
    req = "R10"; rd(2'd1); rd(2'd3); idle(1);

    // R2/R8/R9: full pass over slot 1, overrun window, then repeat
    sel(1);
    req = "R2"; for (int i = 0; i < 320; i++) rd(2'd2);
    req = "R9"; for (int i = 0; i < 192; i++) rd(2'd2);
    for (int i = 0; i < 20; i++) rd(2'd2);

    // R7: reselect rewinds counter
    req = "R7"; sel(0);
    for (int i = 0; i < 40; i++) rd(2'd2);
    sel(0);
    for (int i = 0; i < 10; i++) rd(2'd2);
    sel(2);
    for (int i = 0; i < 5; i++) rd(2'd2);

    // R8: counter holds across idle cycles
    req = "R8";
    for (int i = 0; i < 3; i++) rd(2'd2);
    idle(5);
    for (int i = 0; i < 3; i++) rd(2'd2);

    // R3: rest of the frame, slot wraps modulo 4
    req = "R3";
    for (int r = 3; r < 18; r++) begin
      feed_row();
      req = (r == 17) ? "R5" : "R4"; rd(2'd0); idle(1); req = "R3";
    end
    // R5: vertical-blank code persists (expected 0x8A)
    req = "R5"; idle(6); rd(2'd0); idle(1);

    // R2: last row of the frame sits in slot 1
    req = "R2"; sel(1);
    for (int i = 0; i < 320; i++) rd(2'd2);

    // R6: vsync clears row but keeps slot (expect 0x02), then mid-row vsync
    req = "R6"; vs_pulse(); rd(2'd0); idle(1);
    for (int l = 0; l < 3; l++) feed_line();
    vs_pulse();
    feed_row();
    rd(2'd0); idle(1);

    req = "R2"; sel(2);
    for (int i = 0; i < 320; i++) rd(2'd2);
    idle(2);

    finished = 1;
    summary();
    $finish;
  end

endmodule